// File: doc/BRIEF.md
# Planar Pixel Format Serializer

This block sits in a display refresh path between the frame-buffer fetch and the colour lookup. Once per character clock the refresh logic hands it one 32-bit word that holds four byte-wide memory planes, and asserts a fetch strobe. Over the next eight dot clocks the block sends out one pixel index per clock, with a valid strobe beside it. A 2-bit format code chooses how bits are gathered from the planes: a four-plane format that builds each pixel from one bit of every plane, an interleaved format that builds each pixel from 2-bit pairs of two planes, and a byte-per-pixel format that sends whole plane bytes.

The format code and the word are captured together on the fetch strobe. Changes to either input during a run take effect only at the next strobe. If the refresh logic strobes every eight clocks, the pixel stream has no gaps. If no new word arrives after the eighth pixel, the valid strobe drops and the pixel output keeps its last value.

Top module: `planar_pixel_serializer`

## Requirements
- R1: After reset, `pix_o` is 0 and `pix_valid_o` is low, and both stay so until the first fetch strobe is captured.
- R2: A fetch strobe (`fetch_i` high at a rising edge) captures `word_i` and `fmt_i`. Pixel slot 0 appears on `pix_o` with `pix_valid_o` high from that same edge. Slots 1 to 7 follow on the next seven edges. Plane k is `word_i[8k+7:8k]`.
- R3: A fetch strobe during a run stops that run at once. The next pixel is slot 0 of the newly captured word.
- R4: After slot 7, if no strobe arrives, `pix_valid_o` goes low and `pix_o` holds the slot-7 value. `word_i` and `fmt_i` have no effect on the output while the block is idle.
- R5: Format code 2'b00 (four-plane): slot s (0..7) is {plane3[7-s], plane2[7-s], plane1[7-s], plane0[7-s]} in bits [3:0].
- R6: Format code 2'b01 (interleaved), slots 0..3: bits [3:2] are plane2 bits [7-2s:6-2s] and bits [1:0] are plane0 bits [7-2s:6-2s].
- R7: Format code 2'b01, slots 4..7: with j = s-4, bits [3:2] are plane3 bits [7-2j:6-2j] and bits [1:0] are plane1 bits [7-2j:6-2j].
- R8: Format codes 2'b10 and 2'b11 (byte per pixel): slots 2i and 2i+1 both carry all eight bits of plane i, for planes 0, 1, 2, 3 in that order.
- R9: In the two 4-bit formats, `pix_o[7:4]` is 0.
- R10: With strobes exactly eight clocks apart, `pix_valid_o` stays high without a break and the slots of successive words follow one another directly.
- R11: Changes to `fmt_i` or `word_i` after a strobe do not alter the pixels of the run already under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_i | input | 1 | Character-clock fetch strobe; captures a new word |
| word_i | input | 32 | Four planes, plane k in bits [8k+7:8k] |
| fmt_i | input | 2 | Gather format: 00 four-plane, 01 interleaved, 1x byte per pixel |
| pix_o | output | 8 | Pixel index, zero-extended for 4-bit formats |
| pix_valid_o | output | 1 | High while a slot of a captured word is on `pix_o` |

## Verification
Two situations are hard to reach from the ports. The first is a fetch strobe that lands partway through a run: the bench issues a strobe only three clocks after the previous one, and the scoreboard throws away the expected slots that are still pending, so any leftover pixel of the old word counts as a mismatch. The second is a change to the format and word inputs in the middle of a run. Right after the capture edge the driver inverts the word and flips the format code between four-plane and byte modes. The expected values still come from the captured pair, so a design that reads the live inputs fails at once.

// File: rtl/pps_pkg.sv
package pps_pkg;

   localparam int NUM_PLANES = 4;

   typedef enum logic [1:0] {
      FMT_PLANAR     = 2'b00,
      FMT_INTERLEAVE = 2'b01,
      FMT_BYTE       = 2'b10,
      FMT_BYTE_ALT   = 2'b11
   } pix_fmt_e;

   function automatic logic fmt_is_byte(input pix_fmt_e f);
      return f[1];
   endfunction

endpackage

// File: rtl/pps_slot_ctrl.sv
module pps_slot_ctrl #(
   parameter  int SLOTS = 8,
   localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   output logic [SW-1:0] cur_o,
   output logic [SW-1:0] nxt_o,
   output logic          run_o,
   output logic          upd_o
);

   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

   if (SLOTS < 2) begin : g_bad_slots
      $error("pps_slot_ctrl: SLOTS must be at least 2");
   end

   logic [SW-1:0] cur_q;
   logic          run_q;
   logic          at_last;

   assign at_last = (cur_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cur_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (at_last) begin
            run_q <= 1'b0;
         end else begin
            cur_q <= cur_q + 1'b1;
         end
      end
   end

   assign cur_o = cur_q;
   assign run_o = run_q;
   assign upd_o = load_i | (run_q & ~at_last);
   assign nxt_o = load_i ? '0 : cur_q + 1'b1;

   AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (run_o && cur_o == '0)) else $error("restart failed"); // R3

   AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && cur_o == LAST && !load_i) |=> !run_o) else $error("run overran"); // R4

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && cur_o != LAST && !load_i) |=> (cur_o == $past(cur_o) + 1'b1)) else $error("slot skipped"); // R2

endmodule

// File: rtl/pps_gather.sv
module pps_gather
   import pps_pkg::*;
#(
   parameter  int PLANE_W = 8,
   parameter  int PIX_W   = 8,
   localparam int PLANES  = NUM_PLANES,
   localparam int DW      = PLANES * PLANE_W,
   localparam int SW      = $clog2(PLANE_W),
   localparam int HALF    = PLANE_W / 2,
   localparam int HOLD    = PLANE_W / PLANES
) (
   input  logic [DW-1:0]    word_i,
   input  pix_fmt_e         fmt_i,
   input  logic [SW-1:0]    idx_i,
   output logic [PIX_W-1:0] pix_o
);

   logic [PLANE_W-1:0] plane   [PLANES];
   logic [PIX_W-1:0]   plan_t  [PLANE_W];
   logic [PIX_W-1:0]   ilv_t   [PLANE_W];
   logic [PIX_W-1:0]   byte_t  [PLANE_W];

   for (genvar k = 0; k < PLANES; k++) begin : g_plane
      assign plane[k] = word_i[k*PLANE_W +: PLANE_W];
   end

   for (genvar s = 0; s < PLANE_W; s++) begin : g_slot
      logic [PLANES-1:0] nib;
      for (genvar k = 0; k < PLANES; k++) begin : g_bit
         assign nib[k] = plane[k][PLANE_W-1-s];
      end
      assign plan_t[s] = PIX_W'(nib);

      if (s < HALF) begin : g_lo
         localparam int TOP = PLANE_W - 1 - 2*s;
         assign ilv_t[s] = PIX_W'({plane[2][TOP -: 2], plane[0][TOP -: 2]});
      end else begin : g_hi
         localparam int TOP = PLANE_W - 1 - 2*(s - HALF);
         assign ilv_t[s] = PIX_W'({plane[3][TOP -: 2], plane[1][TOP -: 2]});
      end

      assign byte_t[s] = PIX_W'(plane[s / HOLD]);
   end

   always_comb begin
      unique case (fmt_i)
         FMT_PLANAR:     pix_o = plan_t[idx_i];
         FMT_INTERLEAVE: pix_o = ilv_t[idx_i];
         default:        pix_o = byte_t[idx_i];
      endcase
   end

endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer
   import pps_pkg::*;
#(
   parameter  int PLANE_W = 8,
   parameter  int PIX_W   = 8,
   localparam int PLANES  = NUM_PLANES,
   localparam int DW      = PLANES * PLANE_W,
   localparam int SLOTS   = PLANE_W,
   localparam int SW      = $clog2(SLOTS),
   localparam int HOLD    = PLANE_W / PLANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_i,
   input  logic [DW-1:0]    word_i,
   input  logic [1:0]       fmt_i,
   output logic [PIX_W-1:0] pix_o,
   output logic             pix_valid_o
);

   if (PLANE_W % PLANES != 0 || PLANE_W < PLANES) begin : g_bad_plane
      $error("planar_pixel_serializer: PLANE_W must be a multiple of the plane count");
   end
   if (PIX_W < PLANE_W || PIX_W <= PLANES) begin : g_bad_pix
      $error("planar_pixel_serializer: PIX_W must hold a full plane byte");
   end

   logic [DW-1:0]    word_q;
   pix_fmt_e         fmt_q;
   logic [PIX_W-1:0] pix_q;
   logic [SW-1:0]    cur_slot;
   logic [SW-1:0]    nxt_slot;
   logic             run;
   logic             upd;
   logic [DW-1:0]    src_word;
   pix_fmt_e         src_fmt;
   logic [PIX_W-1:0] gathered;

   pps_slot_ctrl #(.SLOTS(SLOTS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (fetch_i),
      .cur_o  (cur_slot),
      .nxt_o  (nxt_slot),
      .run_o  (run),
      .upd_o  (upd)
   );

   assign src_word = fetch_i ? word_i : word_q;
   assign src_fmt  = fetch_i ? pix_fmt_e'(fmt_i) : fmt_q;

   pps_gather #(.PLANE_W(PLANE_W), .PIX_W(PIX_W)) u_gather (
      .word_i (src_word),
      .fmt_i  (src_fmt),
      .idx_i  (nxt_slot),
      .pix_o  (gathered)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         fmt_q  <= FMT_PLANAR;
         pix_q  <= '0;
      end else begin
         if (fetch_i) begin
            word_q <= word_i;
            fmt_q  <= pix_fmt_e'(fmt_i);
         end
         if (upd) begin
            pix_q <= gathered;
         end
      end
   end

   assign pix_o       = pix_q;
   assign pix_valid_o = run;

   AST_VALID_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_i |=> pix_valid_o) else $error("no valid after fetch"); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_i && !pix_valid_o) |=> ($stable(pix_o) && !pix_valid_o)) else $error("idle output moved"); // R4

   AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_o && !fmt_is_byte(fmt_q)) |-> ((pix_o >> PLANES) == '0)) else $error("upper bits set"); // R9

   AST_BYTE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_o && fmt_is_byte(fmt_q) && (int'(cur_slot) % HOLD) != 0) |-> $stable(pix_o)) else $error("byte pixel not repeated"); // R8

endmodule

// File: tb/tb_planar_pixel_serializer.sv
module tb_planar_pixel_serializer;

   typedef struct {
      logic [7:0] pix;
      string      tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch = 1'b0;
   logic [31:0] word = '0;
   logic [1:0]  fmt = 2'b00;
   logic [7:0]  pix;
   logic        pix_valid;

   int          n_checks = 0;
   int          n_fails  = 0;
   bit          mon_en   = 1'b0;
   bit          started  = 1'b0;
   bit          done     = 1'b0;
   logic [7:0]  last_pix = 8'h00;
   item_t       sb[$];

   always #4 clk = ~clk;

   planar_pixel_serializer dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_i     (fetch),
      .word_i      (word),
      .fmt_i       (fmt),
      .pix_o       (pix),
      .pix_valid_o (pix_valid)
   );

   function automatic logic [7:0] exp_pix(input logic [31:0] d, input logic [1:0] f, input int s);
      logic [7:0] p [4];
      for (int k = 0; k < 4; k++) p[k] = d[8*k +: 8];
      if (f == 2'b00) begin
         return {4'b0, p[3][7-s], p[2][7-s], p[1][7-s], p[0][7-s]};
      end else if (f == 2'b01) begin
         if (s < 4) return {4'b0, 2'((p[2] >> (6 - 2*s)) & 8'h3), 2'((p[0] >> (6 - 2*s)) & 8'h3)};
         else       return {4'b0, 2'((p[3] >> (14 - 2*s)) & 8'h3), 2'((p[1] >> (14 - 2*s)) & 8'h3)};
      end else begin
         return p[s/2];
      end
   endfunction

   function automatic string auto_tag(input logic [1:0] f, input int s);
      if (f == 2'b00) return "R5";
      if (f == 2'b01) return (s < 4) ? "R6" : "R7";
      return "R8";
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Driver: called at posedge+2; returns at posedge+2 after 'stay' slots.
   task automatic send(input logic [31:0] d, input logic [1:0] f, input int stay,
                       input string tag = "", input bit scramble = 1'b0);
      fetch = 1'b1;
      word  = d;
      fmt   = f;
      @(posedge clk); #2;
      fetch = 1'b0;
      started = 1'b1;
      sb.delete();
      for (int s = 0; s < 8; s++) begin
         item_t it;
         it.pix = exp_pix(d, f, s);
         it.tag = (tag != "") ? tag : auto_tag(f, s);
         sb.push_back(it);
      end
      if (scramble) begin
         word = ~d;
         fmt  = f ^ 2'b10;
      end
      for (int c = 1; c < stay; c++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic idle(input int n);
      for (int c = 0; c < n; c++) begin
         word = word ^ 32'h5A3C_96E1;
         fmt  = fmt + 2'b01;
         @(posedge clk); #2;
      end
   endtask

   // Monitor: pops the scoreboard at every falling edge.
   always @(negedge clk) begin
      if (mon_en) begin
         item_t it;
         string t;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check(pix_valid == 1'b1, (it.tag == "R10") ? "R10" : "R2", "valid low during run",
                  32'(pix_valid), 32'h1);
            check(pix == it.pix, it.tag, "pixel", 32'(pix), 32'(it.pix));
            last_pix = it.pix;
         end else begin
            t = started ? "R4" : "R1";
            check(pix_valid == 1'b0, t, "valid while idle", 32'(pix_valid), 32'h0);
            check(pix == last_pix, t, "idle pixel", 32'(pix), 32'(last_pix));
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R2 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n  = 1'b1;
      mon_en = 1'b1;
      idle(3);

      // four-plane format
      send(32'h0F33_55FF, 2'b00, 8);
      idle(2);
      send(32'h8142_2418, 2'b00, 8);
      idle(1);
      send(32'hFFFF_FFFF, 2'b00, 8, "R9");
      idle(2);

      // interleaved format
      send(32'h1BE4_728D, 2'b01, 8);
      idle(2);
      send(32'hC3A5_0FF0, 2'b01, 8);
      idle(1);
      send(32'hFFFF_FFFF, 2'b01, 8, "R9");
      idle(2);

      // byte per pixel, both codes
      send(32'h4433_2211, 2'b10, 8);
      idle(2);
      send(32'hA0B0_C0D0, 2'b11, 8);
      idle(2);

      // back-to-back words, no gap
      send(32'h1234_5678, 2'b00, 8, "R10");
      send(32'h9ABC_DEF0, 2'b01, 8, "R10");
      send(32'h0102_0304, 2'b10, 8, "R10");
      idle(3);

      // fetch in the middle of a run
      send(32'hDEAD_BEEF, 2'b00, 3);
      send(32'h7766_5544, 2'b10, 8, "R3");
      idle(2);
      send(32'h55AA_33CC, 2'b01, 5);
      send(32'hF0E1_D2C3, 2'b00, 8, "R3");
      idle(2);

      // inputs change after capture
      send(32'h3C5A_96F0, 2'b00, 8, "R11", 1'b1);
      idle(1);
      send(32'h0819_2A3B, 2'b10, 8, "R11", 1'b1);
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule